// File: doc/BRIEF.md
# Dual-Mode Interrupt Priority Router

This block gathers the interrupt requests of five peripheral sources and presents a single prioritised request to the CPU. The sources are a first timer/input controller, a second controller, an Ethernet controller, a serial controller and a non-maskable source. The block drives a 3-bit priority level and an 8-bit autovector number. A mode input selects one of two routing tables, and that table decides which of seven pending bits a source lands on. In the classic table (mode high) the Ethernet request does not reach the CPU path. It is instead reflected on a redirect line that the board wires to a slot interrupt of the second controller.

Every request input is level-sensitive, but the block acts on its transitions. A rising request sets the pending bit that the table in force at that moment assigns to it. A falling request clears the bit that the table in force at that moment assigns. Because of this, switching the mode leaves bits that are already pending where they are.

A separate trigger input, meant for a debug monitor, raises the non-maskable request and keeps it raised for a parameterised number of clock ticks. The output level and vector are registered from the next value of the pending register.

Top module: `irq_prio_router`

## Requirements
- R1: With `mode_i` high, source bit 0 (controller 1) sets pending bit 0, source bit 1 (controller 2) sets bit 1, source bit 3 (serial) sets bit 3 and source bit 4 (NMI) sets bit 6. These give CPU levels 1, 2, 4 and 7.
- R2: With `mode_i` high, a transition of source bit 2 (Ethernet) copies its new level onto `redirect_o` and changes no pending bit.
- R3: With `mode_i` low, source bit 0 sets pending bit 5, bit 1 sets bit 1, bit 2 sets bit 2, bit 3 sets bit 3 and bit 4 sets bit 6. These give levels 6, 2, 3, 4 and 7. `redirect_o` keeps its value.
- R4: A rising request sets its mapped pending bit. A falling request clears it.
- R5: `cpu_level_o` equals one plus the index of the highest set pending bit, and `cpu_vector_o` equals that index plus 25.
- R6: With no pending bit set, both `cpu_level_o` and `cpu_vector_o` are 0.
- R7: A one-cycle pulse on `nmi_trig_i` raises the NMI request from that cycle onward. Level 7 is visible for HOLD_TICKS+1 clock edges, starting with the edge that samples the trigger. The level drops after the next edge.
- R8: A trigger that arrives while a hold is running reloads the hold, so level 7 lasts HOLD_TICKS+1 edges from the new trigger.
- R9: A change of `mode_i` does not move pending bits. A fall that arrives after the change clears the bit of the new table only.
- R10: While `rst_n` is low, all pending bits, `redirect_o`, the level, the vector and any NMI hold are cleared.
- R11: The level and vector change on the first clock edge after an input changes, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Routing table select: 1 classic, 0 alternate |
| src_req_i | input | 5 | Request levels: 0 ctrl1, 1 ctrl2, 2 Ethernet, 3 serial, 4 NMI |
| nmi_trig_i | input | 1 | Monitor trigger that starts a timed NMI hold |
| cpu_level_o | output | 3 | Priority level to the CPU, 0 means none |
| cpu_vector_o | output | 8 | Autovector number, 0 when idle |
| redirect_o | output | 1 | Ethernet request forwarded to the slot interrupt in classic mode |

## Verification
A Gray-code walk over all 32 request combinations runs in each mode. Each step toggles one source, which exercises both the set and the clear path and shows whether the priority picks the highest mapped bit, not the most recent one. A second sweep starts each pattern from an idle state, so a stuck or misrouted bit cannot hide behind state left by the walk. Directed sequences cover mode switching with a request held pending, NMI holds with and without retrigger, reset in the middle of a hold, and the one-edge output latency.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int NUM_SRC  = 5;
  localparam int PEND_W   = 7;
  localparam int IDX_W    = 3;

  localparam int SRC_CTL1 = 0;
  localparam int SRC_CTL2 = 1;
  localparam int SRC_ETH  = 2;
  localparam int SRC_SER  = 3;
  localparam int SRC_NMI  = 4;

  typedef struct packed {
    logic             to_pend;
    logic             to_redir;
    logic [IDX_W-1:0] bit_idx;
  } route_t;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
  } top_t;

  // Routing table lookup: classic = 1 selects the table with Ethernet redirect
  function automatic route_t route_of(input int src, input logic classic);
    route_t r;
    r.to_pend  = 1'b1;
    r.to_redir = 1'b0;
    r.bit_idx  = '0;
    case (src)
      SRC_CTL1: r.bit_idx = classic ? 3'd0 : 3'd5;
      SRC_CTL2: r.bit_idx = 3'd1;
      SRC_ETH: begin
        if (classic) begin
          r.to_pend  = 1'b0;
          r.to_redir = 1'b1;
        end else begin
          r.bit_idx = 3'd2;
        end
      end
      SRC_SER:  r.bit_idx = 3'd3;
      SRC_NMI:  r.bit_idx = 3'd6;
      default:  r.to_pend = 1'b0;
    endcase
    return r;
  endfunction

  // Highest set bit of the pending vector
  function automatic top_t top_index(input logic [PEND_W-1:0] p);
    top_t t;
    t.valid = 1'b0;
    t.idx   = '0;
    for (int i = 0; i < PEND_W; i++) begin
      if (p[i]) begin
        t.valid = 1'b1;
        t.idx   = IDX_W'(i);
      end
    end
    return t;
  endfunction

endpackage

// File: rtl/irq_edge_sense.sv
module irq_edge_sense #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;

endmodule

// File: rtl/irq_nmi_stretch.sv
module irq_nmi_stretch #(
  parameter int HOLD_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic req_i,
  output logic nmi_o,
  output logic hold_o
);

  localparam int CNT_W = $clog2(HOLD_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (trig_i)           cnt_q <= CNT_W'(HOLD_TICKS);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);
  assign nmi_o  = req_i | trig_i | hold_o;

endmodule

// File: rtl/irq_pend_map.sv
module irq_pend_map
  import irq_router_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_i,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] fall_i,
  output logic [PEND_W-1:0]  pend_o,
  output logic [PEND_W-1:0]  pend_next_o,
  output logic               redirect_o
);

  logic [PEND_W-1:0] pend_q, pend_d;
  logic              redir_q, redir_d;

  always_comb begin
    route_t r;
    pend_d  = pend_q;
    redir_d = redir_q;
    for (int s = 0; s < NUM_SRC; s++) begin
      r = route_of(s, mode_i);
      if (rise_i[s]) begin
        if (r.to_pend)  pend_d[r.bit_idx] = 1'b1;
        if (r.to_redir) redir_d = 1'b1;
      end else if (fall_i[s]) begin
        if (r.to_pend)  pend_d[r.bit_idx] = 1'b0;
        if (r.to_redir) redir_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      redir_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      redir_q <= redir_d;
    end
  end

  assign pend_o      = pend_q;
  assign pend_next_o = pend_d;
  assign redirect_o  = redir_q;

endmodule

// File: rtl/irq_prio_encode.sv
module irq_prio_encode
  import irq_router_pkg::*;
#(
  parameter int LEVEL_W  = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PEND_W-1:0]  pend_i,
  output logic [LEVEL_W-1:0] level_o,
  output logic [VEC_W-1:0]   vector_o
);

  top_t               top;
  logic [LEVEL_W-1:0] level_d;
  logic [VEC_W-1:0]   vector_d;

  always_comb begin
    top = top_index(pend_i);
    if (top.valid) begin
      level_d  = LEVEL_W'(top.idx) + LEVEL_W'(1);
      vector_d = VEC_W'(VEC_BASE) + VEC_W'(top.idx);
    end else begin
      level_d  = '0;
      vector_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_o  <= '0;
      vector_o <= '0;
    end else begin
      level_o  <= level_d;
      vector_o <= vector_d;
    end
  end

endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
  import irq_router_pkg::*;
#(
  parameter int HOLD_TICKS = 16,
  parameter int LEVEL_W    = 3,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_i,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               nmi_trig_i,
  output logic [LEVEL_W-1:0] cpu_level_o,
  output logic [VEC_W-1:0]   cpu_vector_o,
  output logic               redirect_o
);

  logic               nmi_eff;
  logic               nmi_hold;
  logic [NUM_SRC-1:0] req_eff;
  logic [NUM_SRC-1:0] src_rise;
  logic [NUM_SRC-1:0] src_fall;
  logic [PEND_W-1:0]  pend_q;
  logic [PEND_W-1:0]  pend_nxt;

  irq_nmi_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (nmi_trig_i),
    .req_i  (src_req_i[SRC_NMI]),
    .nmi_o  (nmi_eff),
    .hold_o (nmi_hold)
  );

  always_comb begin
    req_eff          = src_req_i;
    req_eff[SRC_NMI] = nmi_eff;
  end

  irq_edge_sense #(.W(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (req_eff),
    .rise_o (src_rise),
    .fall_o (src_fall)
  );

  irq_pend_map u_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .rise_i      (src_rise),
    .fall_i      (src_fall),
    .pend_o      (pend_q),
    .pend_next_o (pend_nxt),
    .redirect_o  (redirect_o)
  );

  irq_prio_encode #(
    .LEVEL_W  (LEVEL_W),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
  ) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_i   (pend_nxt),
    .level_o  (cpu_level_o),
    .vector_o (cpu_vector_o)
  );

endmodule

// File: rtl/irq_prio_router_chk.sv
module irq_prio_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_i,
  input logic       nmi_trig_i,
  input logic [2:0] cpu_level_o,
  input logic [7:0] cpu_vector_o,
  input logic       redirect_o,
  input logic [4:0] src_rise,
  input logic [4:0] src_fall,
  input logic [6:0] pend_q,
  input logic       nmi_hold
);

  // R5: vector follows level
  a_r5_vector_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_level_o != 3'd0) |-> (cpu_vector_o == 8'(cpu_level_o) + 8'd24));

  // R6: idle vector
  a_r6_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_level_o == 3'd0) |-> (cpu_vector_o == 8'd0));

  // R7: trigger reaches level 7 one edge later
  a_r7_trigger_to_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_trig_i |=> (cpu_level_o == 3'd7));

  // R8: trigger arms the hold
  a_r8_hold_armed: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_trig_i |=> nmi_hold);

  // R2: classic Ethernet rise goes to redirect
  a_r2_eth_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && src_rise[2]) |=> redirect_o);

  // R2: classic Ethernet edges leave pending bit 2 alone
  a_r2_eth_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && (src_rise[2] || src_fall[2])) |=> $stable(pend_q[2]));

  // R3: alternate Ethernet rise sets pending bit 2
  a_r3_eth_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && src_rise[2]) |=> pend_q[2]);

  // R4: alternate controller-1 fall clears bit 5
  a_r4_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && src_fall[0]) |=> !pend_q[5]);

endmodule

bind irq_prio_router irq_prio_router_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .nmi_trig_i   (nmi_trig_i),
  .cpu_level_o  (cpu_level_o),
  .cpu_vector_o (cpu_vector_o),
  .redirect_o   (redirect_o),
  .src_rise     (src_rise),
  .src_fall     (src_fall),
  .pend_q       (pend_q),
  .nmi_hold     (nmi_hold)
);

// File: tb/irq_prio_router_tb_top.sv
module irq_prio_router_tb_top;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_i;
  logic [4:0] src_req_i;
  logic       nmi_trig_i;
  logic [2:0] cpu_level_o;
  logic [7:0] cpu_vector_o;
  logic       redirect_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_router #(.HOLD_TICKS(N)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .src_req_i    (src_req_i),
    .nmi_trig_i   (nmi_trig_i),
    .cpu_level_o  (cpu_level_o),
    .cpu_vector_o (cpu_vector_o),
    .redirect_o   (redirect_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Level each source reaches, by mode (from R1 / R3)
  function automatic int src_level(input int s, input bit classic);
    int lv_c[5] = '{1, 2, 0, 4, 7};
    int lv_a[5] = '{6, 2, 3, 4, 7};
    return classic ? lv_c[s] : lv_a[s];
  endfunction

  function automatic int exp_level(input logic [4:0] p, input bit classic);
    int best = 0;
    for (int s = 0; s < 5; s++)
      if (p[s] && src_level(s, classic) > best) best = src_level(s, classic);
    return best;
  endfunction

  task automatic check_out(input string req, input int lv, input int rd);
    chk({req, " level"}, cpu_level_o, lv);
    chk({req, " vector"}, cpu_vector_o, (lv == 0) ? 0 : lv + 24);
    chk({req, " redirect"}, redirect_o, rd);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    check_out("R10 in reset", 0, 0);
    src_req_i  = '0;
    nmi_trig_i = 1'b0;
    mode_i     = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    mode_i     = 1'b0;
    src_req_i  = '0;
    nmi_trig_i = 1'b0;
    @(negedge clk);
    tick();
    check_out("R10 reset state", 0, 0);
    rst_n = 1'b1;
    tick();
    check_out("R6 idle after reset", 0, 0);

    // Gray walk, both modes (R1 R2 R3 R4 R5)
    for (int m = 0; m < 2; m++) begin
      mode_i = m[0];
      for (int g = 0; g < 32; g++) begin
        logic [4:0] pat;
        pat = 5'(g ^ (g >> 1));
        src_req_i = pat;
        tick();
        check_out(m ? "R1 R2 R5 gray classic" : "R3 R4 R5 gray alt",
                  exp_level(pat, m[0]), m ? int'(pat[2]) : 0);
      end
      src_req_i = '0;
      tick();
      check_out("R4 R6 cleared", 0, 0);
    end

    // Isolated patterns from idle (R1 R3 R4 R6)
    for (int m = 0; m < 2; m++) begin
      mode_i = m[0];
      for (int p = 1; p < 32; p++) begin
        src_req_i = 5'(p);
        tick();
        check_out(m ? "R1 R2 isolated" : "R3 isolated",
                  exp_level(5'(p), m[0]), m ? int'(p[2]) : 0);
        src_req_i = '0;
        tick();
        check_out("R4 R6 released", 0, 0);
      end
    end

    // R11 latency
    mode_i = 1'b0;
    src_req_i = 5'b01000;
    #2;
    chk("R11 before edge", cpu_level_o, 0);
    tick();
    chk("R11 after edge", cpu_level_o, 4);
    src_req_i = '0;
    tick();

    // R9 mode change keeps pending bit
    mode_i = 1'b0;
    src_req_i = 5'b00001;
    tick();
    chk("R9 alt ctl1", cpu_level_o, 6);
    mode_i = 1'b1;
    tick();
    chk("R9 after switch", cpu_level_o, 6);
    src_req_i = 5'b00000;
    tick();
    chk("R9 fall new table", cpu_level_o, 6);
    src_req_i = 5'b00010;
    tick();
    chk("R9 ctl2 under stale", cpu_level_o, 6);
    src_req_i = 5'b00100;
    tick();
    check_out("R2 redirect with stale", 6, 1);
    do_reset();
    check_out("R10 cleared pending", 0, 0);

    // R7 NMI hold
    nmi_trig_i = 1'b1;
    tick();
    nmi_trig_i = 1'b0;
    chk("R7 trigger edge", cpu_level_o, 7);
    for (int i = 1; i <= N; i++) begin
      tick();
      chk("R7 hold", cpu_level_o, 7);
    end
    tick();
    chk("R7 released", cpu_level_o, 0);

    // R8 retrigger reloads
    nmi_trig_i = 1'b1;
    tick();
    nmi_trig_i = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    nmi_trig_i = 1'b1;
    tick();
    nmi_trig_i = 1'b0;
    chk("R8 retrigger", cpu_level_o, 7);
    for (int i = 1; i <= N; i++) begin
      tick();
      chk("R8 reloaded hold", cpu_level_o, 7);
    end
    tick();
    chk("R8 released", cpu_level_o, 0);

    // R10 reset cancels hold
    nmi_trig_i = 1'b1;
    tick();
    nmi_trig_i = 1'b0;
    tick();
    do_reset();
    chk("R10 hold cancelled", cpu_level_o, 0);
    for (int i = 0; i < N + 2; i++) tick();
    chk("R10 hold stays off", cpu_level_o, 0);

    // R10 reset clears redirect
    mode_i = 1'b1;
    src_req_i = 5'b00100;
    tick();
    chk("R2 redirect set", redirect_o, 1);
    do_reset();
    chk("R10 redirect cleared", redirect_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule